// File: doc/BRIEF.md
# Positional Fixed-Point PID Controller

This block is a sampled three-term controller that computes an absolute (positional) actuator command from a signed control error. On every sample strobe it takes a new error value, adds it to a running sum for the integral term, and forms the backward difference against the error of the previous strobe for the derivative term. It multiplies the current error, the running sum and the difference by three unsigned integer gains, adds the three products in one saturating adder, and then takes a fixed bit slice of that sum as the command. The slice removes the integer scaling of the gains, so fractional gains need no floating point.

The three gains are written through a small parallel write port into a staging bank. A sample strobe copies the staging bank into the working gains. Every sample is therefore computed with one consistent set of gains, however the writes fall. The whole datapath is signed two's complement. The running sum, each product and the total saturate instead of wrapping. The sliced result is saturated to the output width.

Top module: `pid_positional`

## Requirements
- R1: A synchronous active-high `rst` sets `cmd` to 0 and `cmd_valid` to 0. It clears the running error sum, the stored previous error, and both the staging and the working gains to 0.
- R2: For each cycle in which `smp_valid` is high, `cmd_valid` is high for exactly one cycle, three cycles later. `cmd_valid` is never high otherwise. Strobes may arrive in consecutive cycles.
- R3: The command is built from sum = Kp*e(k) + Ki*S(k) + Kd*(e(k) - e(k-1)). The gains are unsigned 8-bit integers and e is the signed 16-bit `smp_err`.
- R4: S(k) is the running sum of every error sample since reset, the current one included. It saturates at +8388607 and -8388608 (24-bit signed).
- R5: e(k-1) is the error of the previous strobe, and it is 0 for the first strobe after reset. Cycles without a strobe do not change it.
- R6: Each of the three products and their total saturate to the 24-bit signed range.
- R7: `cmd` equals the saturated 24-bit total shifted right arithmetically by 7 (rounded toward minus infinity), then saturated to the 16-bit signed range.
- R8: A write with `gain_we` high stores `gain_wdata` into the staging gain chosen by `gain_sel` (0 = proportional, 1 = integral, 2 = derivative). Code 3 is ignored. A strobe computes with the staging values held before that cycle's write, so a write in the same cycle as a strobe first applies at the next strobe.
- R9: `cmd` holds its value in every cycle in which `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_we | input | 1 | Gain write enable |
| gain_sel | input | 2 | Gain select: 0 proportional, 1 integral, 2 derivative, 3 unused |
| gain_wdata | input | 8 | Unsigned gain value to write |
| smp_valid | input | 1 | Sample strobe |
| smp_err | input | 16 | Signed error sample (setpoint minus feedback) |
| cmd_valid | output | 1 | Command valid pulse |
| cmd | output | 16 | Signed actuator command |

## Verification
A gain write and a sample strobe can fall in the same cycle. The bench provokes this by driving `gain_we` together with `smp_valid`, both with a valid selector and with the unused code 3. The scoreboard model copies the staging gains into the working gains before it applies the write. The collision is judged by comparing the command of that strobe, which must still use the old gain, and of the following strobe, which must use the new gain. Saturation of the running sum, the products and the output slice is driven by long runs of full-scale errors of either sign.

// File: rtl/pidp_pkg.sv
package pidp_pkg;
   // gain slot order inside the gain bank
   localparam int GAIN_P   = 0;
   localparam int GAIN_I   = 1;
   localparam int GAIN_D   = 2;
   localparam int NUM_GAIN = 3;
   // fixed number of register stages from strobe to command
   localparam int PIPE_LAT = 3;
endpackage

// File: rtl/pidp_sat.sv
module pidp_sat #(
   parameter int IN_W  = 25,
   parameter int OUT_W = 24
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   generate
      if (IN_W <= OUT_W) begin : g_extend
         assign dout = OUT_W'(din);
      end else begin : g_clip
         localparam int HI_W = IN_W - OUT_W + 1;
         logic [HI_W-1:0] hi;
         logic            fits;
         assign hi   = din[IN_W-1:OUT_W-1];
         assign fits = (&hi) | ~(|hi);
         always_comb begin
            if (fits)
               dout = din[OUT_W-1:0];
            else if (din[IN_W-1])
               dout = {1'b1, {(OUT_W-1){1'b0}}};
            else
               dout = {1'b0, {(OUT_W-1){1'b1}}};
         end
      end
   endgenerate
endmodule

// File: rtl/pidp_gains.sv
module pidp_gains
   import pidp_pkg::*;
#(
   parameter int GAIN_W = 8
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               wr_en,
   input  logic [1:0]                         wr_sel,
   input  logic [GAIN_W-1:0]                  wr_data,
   input  logic                               load,
   output logic [NUM_GAIN-1:0][GAIN_W-1:0]    gains
);
   logic [NUM_GAIN-1:0][GAIN_W-1:0] staged_q;
   logic [NUM_GAIN-1:0][GAIN_W-1:0] active_q;

   for (genvar g = 0; g < NUM_GAIN; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            staged_q[g] <= '0;
            active_q[g] <= '0;
         end else begin
            if (wr_en && (wr_sel == 2'(g)))
               staged_q[g] <= wr_data;
            if (load)
               active_q[g] <= staged_q[g];
         end
      end
   end

   assign gains = active_q;
endmodule

// File: rtl/pidp_front.sv
module pidp_front #(
   parameter int ERR_W = 16,
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [ERR_W-1:0] in_err,
   output logic                    out_valid,
   output logic signed [ERR_W-1:0] err_q,
   output logic signed [ERR_W:0]   diff_q,
   output logic signed [ACC_W-1:0] sum_q
);
   logic signed [ERR_W-1:0] prev_q;
   logic signed [ACC_W:0]   sum_wide;
   logic signed [ACC_W-1:0] sum_next;
   logic signed [ERR_W:0]   diff_next;

   assign sum_wide  = (ACC_W+1)'(sum_q) + (ACC_W+1)'(in_err);
   assign diff_next = (ERR_W+1)'(in_err) - (ERR_W+1)'(prev_q);

   pidp_sat #(.IN_W(ACC_W+1), .OUT_W(ACC_W)) u_sum_sat (
      .din (sum_wide),
      .dout(sum_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         err_q     <= '0;
         diff_q    <= '0;
         sum_q     <= '0;
         prev_q    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            err_q  <= in_err;
            diff_q <= diff_next;
            sum_q  <= sum_next;
            prev_q <= in_err;
         end
      end
   end
endmodule

// File: rtl/pidp_mac.sv
module pidp_mac
   import pidp_pkg::*;
#(
   parameter int ERR_W  = 16,
   parameter int GAIN_W = 8,
   parameter int ACC_W  = 24,
   parameter int OUT_W  = 16,
   parameter int SHIFT  = 7
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             in_valid,
   input  logic [NUM_GAIN-1:0][GAIN_W-1:0]  gains,
   input  logic signed [ERR_W-1:0]          err,
   input  logic signed [ERR_W:0]            diff,
   input  logic signed [ACC_W-1:0]          total,
   output logic                             out_valid,
   output logic signed [OUT_W-1:0]          out_cmd
);
   localparam int PROD_W  = ACC_W + GAIN_W + 1;
   localparam int ADD_W   = ACC_W + 2;
   localparam int SLICE_W = ACC_W - SHIFT;

   logic signed [ACC_W-1:0]  opnd   [NUM_GAIN];
   logic signed [PROD_W-1:0] prod   [NUM_GAIN];
   logic signed [ACC_W-1:0]  prod_s [NUM_GAIN];
   logic signed [ACC_W-1:0]  prod_q [NUM_GAIN];
   logic                     prod_v;

   assign opnd[GAIN_P] = ACC_W'(err);
   assign opnd[GAIN_I] = total;
   assign opnd[GAIN_D] = ACC_W'(diff);

   for (genvar g = 0; g < NUM_GAIN; g++) begin : g_term
      assign prod[g] = PROD_W'(opnd[g]) * PROD_W'($signed({1'b0, gains[g]}));
      pidp_sat #(.IN_W(PROD_W), .OUT_W(ACC_W)) u_prod_sat (
         .din (prod[g]),
         .dout(prod_s[g])
      );
      always_ff @(posedge clk) begin
         if (rst) prod_q[g] <= '0;
         else if (in_valid) prod_q[g] <= prod_s[g];
      end
   end

   logic signed [ADD_W-1:0]   add_w;
   logic signed [ACC_W-1:0]   add_s;
   logic signed [SLICE_W-1:0] slice;
   logic signed [OUT_W-1:0]   slice_s;

   assign add_w = ADD_W'(prod_q[GAIN_P]) + ADD_W'(prod_q[GAIN_I]) + ADD_W'(prod_q[GAIN_D]);

   pidp_sat #(.IN_W(ADD_W), .OUT_W(ACC_W)) u_add_sat (
      .din (add_w),
      .dout(add_s)
   );

   assign slice = add_s[ACC_W-1:SHIFT];

   pidp_sat #(.IN_W(SLICE_W), .OUT_W(OUT_W)) u_out_sat (
      .din (slice),
      .dout(slice_s)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         prod_v    <= 1'b0;
         out_valid <= 1'b0;
         out_cmd   <= '0;
      end else begin
         prod_v    <= in_valid;
         out_valid <= prod_v;
         if (prod_v) out_cmd <= slice_s;
      end
   end
endmodule

// File: rtl/pid_positional.sv
module pid_positional
   import pidp_pkg::*;
#(
   parameter int ERR_W  = 16,
   parameter int GAIN_W = 8,
   parameter int ACC_W  = 24,
   parameter int OUT_W  = 16,
   parameter int SHIFT  = 7
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    gain_we,
   input  logic [1:0]              gain_sel,
   input  logic [GAIN_W-1:0]       gain_wdata,
   input  logic                    smp_valid,
   input  logic signed [ERR_W-1:0] smp_err,
   output logic                    cmd_valid,
   output logic signed [OUT_W-1:0] cmd
);
   // elaboration-time parameter checks
   if (ACC_W <= ERR_W) begin : g_bad_acc
      $error("ACC_W must exceed ERR_W so the backward difference fits");
   end
   if (SHIFT < 0 || SHIFT >= ACC_W - 1) begin : g_bad_shift
      $error("SHIFT must lie in 0 .. ACC_W-2");
   end
   if (GAIN_W < 1 || OUT_W < 2) begin : g_bad_width
      $error("GAIN_W and OUT_W are too small");
   end

   logic [NUM_GAIN-1:0][GAIN_W-1:0] gains;
   logic                            f_valid;
   logic signed [ERR_W-1:0]         f_err;
   logic signed [ERR_W:0]           f_diff;
   logic signed [ACC_W-1:0]         f_sum;

   pidp_gains #(.GAIN_W(GAIN_W)) u_gains (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (gain_we),
      .wr_sel (gain_sel),
      .wr_data(gain_wdata),
      .load   (smp_valid),
      .gains  (gains)
   );

   pidp_front #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_front (
      .clk      (clk),
      .rst      (rst),
      .in_valid (smp_valid),
      .in_err   (smp_err),
      .out_valid(f_valid),
      .err_q    (f_err),
      .diff_q   (f_diff),
      .sum_q    (f_sum)
   );

   pidp_mac #(
      .ERR_W(ERR_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
   ) u_mac (
      .clk      (clk),
      .rst      (rst),
      .in_valid (f_valid),
      .gains    (gains),
      .err      (f_err),
      .diff     (f_diff),
      .total    (f_sum),
      .out_valid(cmd_valid),
      .out_cmd  (cmd)
   );
endmodule

// File: rtl/pidp_chk.sv
module pidp_chk #(
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             smp_valid,
   input logic             cmd_valid,
   input logic [OUT_W-1:0] cmd
);
   // R1: reset drives the command and its strobe to zero
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (cmd == '0 && !cmd_valid));

   // R2: every strobe yields a command three cycles later
   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      smp_valid |=> ##2 cmd_valid);

   // R2: no command without a strobe three cycles earlier
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      !smp_valid |=> ##2 !cmd_valid);

   // R9: command holds while no result is presented
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |-> $stable(cmd));
endmodule

bind pid_positional pidp_chk #(.OUT_W(OUT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .smp_valid(smp_valid),
   .cmd_valid(cmd_valid),
   .cmd      (cmd)
);

// File: tb/tb_pid_positional.sv
`timescale 1ns/1ps
module tb_pid_positional;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              gain_we = 1'b0;
   logic [1:0]        gain_sel = '0;
   logic [7:0]        gain_wdata = '0;
   logic              smp_valid = 1'b0;
   logic signed [15:0] smp_err = '0;
   logic              cmd_valid;
   logic signed [15:0] cmd;

   always #2 clk = ~clk;   // 250 MHz

   pid_positional dut (
      .clk(clk), .rst(rst), .gain_we(gain_we), .gain_sel(gain_sel),
      .gain_wdata(gain_wdata), .smp_valid(smp_valid), .smp_err(smp_err),
      .cmd_valid(cmd_valid), .cmd(cmd)
   );

   int n_checks = 0;
   int n_fail   = 0;
   longint cyc  = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference model state
   longint m_sum, m_prev;
   longint m_stg [3];
   longint m_act [3];
   longint exp_q [$];
   longint when_q[$];
   longint last_cmd = 0;

   function automatic longint sat(input longint v, input int w);
      longint hi, lo;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -(longint'(1) <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
      end
   endtask

   task automatic model_clear();
      m_sum = 0; m_prev = 0;
      for (int i = 0; i < 3; i++) begin m_stg[i] = 0; m_act[i] = 0; end
   endtask

   // driver: one strobe, optional gain write in the same cycle (R8)
   task automatic sample(input longint e, input bit we = 1'b0,
                         input logic [1:0] sel = 2'd0, input logic [7:0] d = 8'd0);
      longint diff, p0, p1, p2, s;
      @(negedge clk);
      smp_valid = 1'b1; smp_err = 16'(e);
      gain_we = we; gain_sel = sel; gain_wdata = d;
      for (int i = 0; i < 3; i++) m_act[i] = m_stg[i];
      m_sum  = sat(m_sum + e, 24);          // R4
      diff   = e - m_prev;                  // R5
      m_prev = e;
      p0 = sat(m_act[0] * e, 24);           // R3 / R6
      p1 = sat(m_act[1] * m_sum, 24);
      p2 = sat(m_act[2] * diff, 24);
      s  = sat(p0 + p1 + p2, 24);
      exp_q.push_back(sat(s >>> 7, 16));    // R7
      when_q.push_back(cyc + 3);            // R2
      if (we && sel != 2'd3) m_stg[sel] = longint'(d);
   endtask

   task automatic write_gain(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      smp_valid = 1'b0; gain_we = 1'b1; gain_sel = sel; gain_wdata = d;
      if (sel != 2'd3) m_stg[sel] = longint'(d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_valid = 1'b0; gain_we = 1'b0;
      end
   endtask

   task automatic do_reset();
      idle(6);
      @(negedge clk); rst = 1'b1;
      idle(2);
      @(negedge clk); rst = 1'b0;
      model_clear();
      @(negedge clk);
      check(cmd == 0, "R1 cmd after reset", longint'(cmd), 0);
      check(cmd_valid == 1'b0, "R1 cmd_valid after reset", longint'(cmd_valid), 0);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst) begin
         last_cmd = 0;
      end else if (cmd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected cmd_valid", 1, 0);
         end else begin
            longint e, w;
            e = exp_q.pop_front();
            w = when_q.pop_front();
            check(cyc == w, "R2 latency", cyc, w);
            check(longint'(cmd) == e, "R3-path command value", longint'(cmd), e);
         end
         last_cmd = longint'(cmd);
      end else begin
         check(longint'(cmd) == last_cmd, "R9 hold", longint'(cmd), last_cmd);
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      model_clear();
      do_reset();                                   // R1

      // R3: proportional only, gain 128 is unity after the slice
      write_gain(2'd0, 8'd128);
      sample(100); sample(-100); sample(32767); sample(-32768); sample(0);
      idle(4);

      // R4 + R5: add integral and derivative, back-to-back strobes (R2)
      write_gain(2'd1, 8'd5);
      write_gain(2'd2, 8'd50);
      sample(1000); sample(1000); sample(-2000); sample(37);
      idle(3);
      sample(-5); idle(2); sample(400); idle(5);   // R5 prev unaffected by gaps

      // R8: write in the same cycle as a strobe applies only from the next strobe
      sample(1200, 1'b1, 2'd0, 8'd7);
      sample(1200);
      sample(-300, 1'b1, 2'd3, 8'd255);             // R8 code 3 ignored
      sample(-300);
      write_gain(2'd3, 8'd99);                      // R8 code 3 ignored
      sample(250);
      idle(5);

      // R4 + R6 + R7: positive integral saturation and output clip
      do_reset();
      write_gain(2'd1, 8'd255);
      for (int i = 0; i < 300; i++) sample(32767);
      for (int i = 0; i < 600; i++) sample(-32768); // R4 negative saturation
      idle(5);

      // R6: derivative product saturation both ways
      do_reset();
      write_gain(2'd2, 8'd255);
      sample(-32768); sample(32767); sample(-32768); sample(0);
      idle(5);

      // R1: state cleared by reset, first strobe uses zero history
      write_gain(2'd0, 8'd200);
      write_gain(2'd1, 8'd90);
      sample(5000); sample(-7000); idle(5);
      do_reset();
      write_gain(2'd1, 8'd90);
      write_gain(2'd2, 8'd30);
      sample(4000); sample(4000); idle(6);

      check(exp_q.size() == 0, "R2 all strobes answered", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule